// File: doc/BRIEF.md
# NAND flash bus timing sequencer

This block turns single accesses from a register-mapped host port into timed cycles on an 8-bit raw NAND flash bus. It drives the command-latch, address-latch, write-strobe, read-strobe and chip-enable lines. Setup, strobe width and hold lengths are programmable, with one set for read cycles and another set for write cycles. A host write into the lower half of the address space becomes a command, address or data cycle, chosen by two offset bits. A host read there becomes a data read cycle. The host port stalls until the bus cycle has finished its hold phase.

After every bus cycle the sequencer waits a programmable number of clock pairs before it samples the device ready/busy line again. It does not start another bus cycle during that wait. Control and status registers sit in the upper half of the address space. They hold a configuration bit that keeps chip enable asserted, the timing word, a ready status, a transfer counter for data cycles and a two-source interrupt block with status, enable, set and clear registers.

Top module: `nand_strobe_seq`

## Requirements
- R1: The timing register at offset 0x44 is 32 bits of eight 4-bit fields and reads back as written. The write group holds ready wait [31:28], strobe width [27:24], hold [23:20] and setup [19:16]. The read group holds ready wait [15:12], width [11:8], hold [7:4] and setup [3:0]. After reset the register reads 0.
- R2: In a write cycle, nCE is low for the setup, strobe and hold phases. The setup phase lasts (write setup + 1) clocks, nWE is low for (write width + 1) clocks, and the hold phase lasts (write hold + 1) clocks. The byte on nand_dout during the strobe equals host_wdata[7:0].
- R3: A host read at any offset below 0x40 runs a data read cycle timed by the read fields, with CLE and ALE low. nRE is low for (read width + 1) clocks. nand_din is captured at the last strobe clock and returned in host_rdata[7:0].
- R4: For a host write below 0x40, offset bit 3 set gives a command cycle with CLE high from setup through hold. Otherwise, offset bit 2 set gives an address cycle with ALE high. Otherwise the cycle is a data cycle with neither line high.
- R5: host_ack is a one-clock pulse. For bus accesses it comes the clock after the hold phase ends. For register accesses it comes one clock after the request.
- R6: After the hold phase of a cycle, the block waits 2*n clocks, where n is the ready-wait field of that cycle's direction. It does not start a new bus cycle during the wait, and the sampled ready value stays frozen for that time.
- R7: Bit 5 of the config register at offset 0x40 keeps nCE low even with no bus cycle running. The bit reads back as written.
- R8: Bit 0 of the status register at offset 0x48 is the sampled ready level. A rising edge of that level sets interrupt status bit 0 at offset 0x4C.
- R9: The transfer counter at offset 0x60 is loaded by a host write. Each completed data cycle decrements it when it is non-zero. A decrement from 1 to 0 sets interrupt status bit 1. Command and address cycles leave it unchanged.
- R10: Writing 1 to a bit of the set register at 0x54 sets that interrupt status bit. Writing 1 to a bit of the clear register at 0x58 clears it. Output irq is high when any status bit is high and the matching bit of the enable register at 0x50 is also high.
- R11: Writing the control register at 0x5C with bit 2 set returns config, timing, enables, interrupt status, counter and sequencer to their reset state. The control register always reads 0.
- R12: With no bus cycle running and bit 5 clear, nCE is high. CLE and ALE are never high together. nWE and nRE are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request, held until host_ack |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 7 | Byte offset; bit 6 selects registers |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | 1 | Chip enable, active low |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Bus data driven in write cycles |
| nand_doe | output | 1 | Output enable for nand_dout |
| nand_din | input | 8 | Bus data from the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| irq | output | 1 | Interrupt request |

## Verification
The sequencer is first driven with write cycles at the data, address, command and combined offsets, all under one asymmetric write timing. Each phase length is measured at the pins, so a swapped field or an off-by-one shows up as a phase of the wrong length. A read with different read fields shows whether reads use their own field group and return the sampled byte. A nonzero ready wait is compared against zero wait by timing the gap before the next cycle and by reading the status during the wait. Counter runs mix command cycles with data cycles, so a counter that steps on every cycle is told apart from one that steps only on data cycles.

// File: rtl/nss_pkg.sv
package nss_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_PULSE = 3'd2,
      PH_HOLD  = 3'd3,
      PH_WAIT  = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      CYC_DATA = 2'd0,
      CYC_ADDR = 2'd1,
      CYC_CMD  = 2'd2
   } cyc_t;

   // register index = host_addr[5:2] in the register half
   localparam int unsigned REG_CFG   = 0;
   localparam int unsigned REG_TIME  = 1;
   localparam int unsigned REG_STAT  = 2;
   localparam int unsigned REG_ISTAT = 3;
   localparam int unsigned REG_IEN   = 4;
   localparam int unsigned REG_ISET  = 5;
   localparam int unsigned REG_ICLR  = 6;
   localparam int unsigned REG_CTRL  = 7;
   localparam int unsigned REG_COUNT = 8;

   localparam int unsigned CFG_FORCE_CE_BIT = 5;
   localparam int unsigned CTRL_SRST_BIT    = 2;
   localparam int unsigned IRQ_RDY          = 0;
   localparam int unsigned IRQ_TC           = 1;
   localparam int unsigned IRQ_NUM          = 2;
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_chk
      $error("nss_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nss_irq.sv
module nss_irq #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] set_wr,
   input  logic [N-1:0] clr_wr,
   input  logic         en_we,
   input  logic [N-1:0] en_d,
   output logic [N-1:0] stat,
   output logic [N-1:0] en,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        stat[i] <= 1'b0;
         else if (srst)                     stat[i] <= 1'b0;
         else if (ev[i] || set_wr[i])       stat[i] <= 1'b1;
         else if (clr_wr[i])                stat[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     en[i] <= 1'b0;
         else if (srst)  en[i] <= 1'b0;
         else if (en_we) en[i] <= en_d[i];
      end

      // R10: a clear with no competing set leaves the bit low
      p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr[i] && !set_wr[i] && !ev[i]) |=> !stat[i]);
      // R10: a set write always lands
      p_set_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (set_wr[i] && !srst) |=> stat[i]);
   end

   assign irq = |(stat & en);
endmodule

// File: rtl/nss_seq.sv
module nss_seq
   import nss_pkg::*;
#(
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst,
   input  logic               start,
   input  logic               start_rd,
   input  cyc_t               start_kind,
   input  logic [DATA_W-1:0]  start_data,
   input  logic [FIELD_W-1:0] t_setup,
   input  logic [FIELD_W-1:0] t_width,
   input  logic [FIELD_W-1:0] t_hold,
   input  logic [FIELD_W-1:0] t_wait,
   output phase_t             phase,
   output logic               done,
   output logic               cap,
   output logic               active,
   output logic               cle,
   output logic               ale,
   output logic               nwe,
   output logic               nre,
   output logic               oe,
   output logic [DATA_W-1:0]  dout
);
   localparam int unsigned CNT_W = FIELD_W + 1;

   logic [CNT_W-1:0]   cnt;
   logic               rd_q;
   cyc_t               kind_q;
   logic [DATA_W-1:0]  data_q;
   logic [FIELD_W-1:0] w_q, h_q, n_q;
   logic               cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         rd_q   <= 1'b0;
         kind_q <= CYC_DATA;
         data_q <= '0;
         w_q    <= '0;
         h_q    <= '0;
         n_q    <= '0;
      end else if (srst) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_SETUP;
               cnt    <= {1'b0, t_setup};
               rd_q   <= start_rd;
               kind_q <= start_kind;
               data_q <= start_data;
               w_q    <= t_width;
               h_q    <= t_hold;
               n_q    <= t_wait;
            end
            PH_SETUP: if (cnt_zero) begin
               phase <= PH_PULSE;
               cnt   <= {1'b0, w_q};
            end else cnt <= cnt - 1'b1;
            PH_PULSE: if (cnt_zero) begin
               phase <= PH_HOLD;
               cnt   <= {1'b0, h_q};
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt_zero) begin
               if (n_q == '0) phase <= PH_IDLE;
               else begin
                  phase <= PH_WAIT;
                  cnt   <= {n_q, 1'b0} - 1'b1;
               end
            end else cnt <= cnt - 1'b1;
            PH_WAIT: if (cnt_zero) phase <= PH_IDLE;
                     else          cnt   <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign active = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
   assign done   = (phase == PH_HOLD) && cnt_zero;
   assign cap    = (phase == PH_PULSE) && cnt_zero && rd_q;
   assign cle    = active && (kind_q == CYC_CMD);
   assign ale    = active && (kind_q == CYC_ADDR);
   assign nwe    = !((phase == PH_PULSE) && !rd_q);
   assign nre    = !((phase == PH_PULSE) && rd_q);
   assign oe     = active && !rd_q;
   assign dout   = data_q;

   // R2: setup always hands over to the strobe phase
   p_setup_to_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (phase == PH_SETUP && cnt_zero) |=> (phase == PH_PULSE));
   // R12: read and write strobes exclusive
   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nwe && !nre));
   // R12: latch lines exclusive
   p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   // R6: a cycle never starts while waiting
   p_no_start_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (phase == PH_WAIT && !cnt_zero) |=> (phase == PH_WAIT));
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nss_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned HOST_W      = 32,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned TC_W        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [HOST_W-1:0] host_rdata,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_nce,
   output logic              nand_nwe,
   output logic              nand_nre,
   output logic [DATA_W-1:0] nand_dout,
   output logic              nand_doe,
   input  logic [DATA_W-1:0] nand_din,
   input  logic              nand_rb,
   output logic              irq
);
   localparam int unsigned TIM_W = 8 * FIELD_W;
   localparam int unsigned GRP_W = 4 * FIELD_W;
   localparam int unsigned IDX_W = ADDR_W - 3;

   if (TIM_W > HOST_W || DATA_W > HOST_W || TC_W > HOST_W) begin : g_chk_w
      $error("nand_strobe_seq: register fields wider than host port");
   end
   if (ADDR_W < 7) begin : g_chk_a
      $error("nand_strobe_seq: ADDR_W must be at least 7");
   end

   // host decode
   logic             is_bus, bus_go, reg_go, reg_wr, srst;
   logic [IDX_W-1:0] idx;
   cyc_t             kind;

   assign is_bus = !host_addr[ADDR_W-1];
   assign idx    = host_addr[ADDR_W-2:2];
   assign kind   = !host_we      ? CYC_DATA :
                   host_addr[3]  ? CYC_CMD  :
                   host_addr[2]  ? CYC_ADDR : CYC_DATA;

   phase_t seq_phase;
   logic   seq_done, seq_cap, seq_act, seq_cle, seq_ale, seq_nwe, seq_nre, seq_oe;
   logic [DATA_W-1:0] seq_dout;

   assign bus_go = host_req && is_bus && !host_ack && (seq_phase == PH_IDLE);
   assign reg_go = host_req && !is_bus && !host_ack;
   assign reg_wr = reg_go && host_we;
   assign srst   = reg_wr && (idx == IDX_W'(REG_CTRL)) && host_wdata[CTRL_SRST_BIT];

   // registers
   logic             force_ce;
   logic [TIM_W-1:0] timing;
   logic [TC_W-1:0]  tcount;
   logic             cur_rd, cur_data;
   logic [DATA_W-1:0] rd_q;
   logic             tc_ev;

   assign tc_ev = seq_done && cur_data && (tcount == TC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_ce <= 1'b0;
         timing   <= '0;
         tcount   <= '0;
      end else if (srst) begin
         force_ce <= 1'b0;
         timing   <= '0;
         tcount   <= '0;
      end else begin
         if (reg_wr && idx == IDX_W'(REG_CFG))  force_ce <= host_wdata[CFG_FORCE_CE_BIT];
         if (reg_wr && idx == IDX_W'(REG_TIME)) timing   <= host_wdata[TIM_W-1:0];
         if (reg_wr && idx == IDX_W'(REG_COUNT)) tcount  <= host_wdata[TC_W-1:0];
         else if (seq_done && cur_data && tcount != '0) tcount <= tcount - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rd   <= 1'b0;
         cur_data <= 1'b0;
         rd_q     <= '0;
      end else begin
         if (bus_go) begin
            cur_rd   <= !host_we;
            cur_data <= (kind == CYC_DATA);
         end
         if (seq_cap) rd_q <= nand_din;
      end
   end

   // timing field selection per direction
   logic [GRP_W-1:0]   grp;
   logic [FIELD_W-1:0] f_setup, f_hold, f_width, f_wait;

   assign grp     = host_we ? timing[TIM_W-1:GRP_W] : timing[GRP_W-1:0];
   assign f_setup = grp[FIELD_W-1:0];
   assign f_hold  = grp[2*FIELD_W-1:FIELD_W];
   assign f_width = grp[3*FIELD_W-1:2*FIELD_W];
   assign f_wait  = grp[4*FIELD_W-1:3*FIELD_W];

   nss_seq #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst),
      .start      (bus_go),
      .start_rd   (!host_we),
      .start_kind (kind),
      .start_data (host_wdata[DATA_W-1:0]),
      .t_setup    (f_setup),
      .t_width    (f_width),
      .t_hold     (f_hold),
      .t_wait     (f_wait),
      .phase      (seq_phase),
      .done       (seq_done),
      .cap        (seq_cap),
      .active     (seq_act),
      .cle        (seq_cle),
      .ale        (seq_ale),
      .nwe        (seq_nwe),
      .nre        (seq_nre),
      .oe         (seq_oe),
      .dout       (seq_dout)
   );

   // ready sampling, frozen while a cycle or its wait runs
   logic rb_sync, rdy_q, rdy_rise;

   nss_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rb),
      .q     (rb_sync)
   );

   assign rdy_rise = (seq_phase == PH_IDLE) && rb_sync && !rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rdy_q <= 1'b0;
      else if (seq_phase == PH_IDLE)  rdy_q <= rb_sync;
   end

   // interrupts
   logic [IRQ_NUM-1:0] istat, ien, iev, iset, iclr;

   assign iev  = {tc_ev, rdy_rise};
   assign iset = (reg_wr && idx == IDX_W'(REG_ISET)) ? host_wdata[IRQ_NUM-1:0] : '0;
   assign iclr = (reg_wr && idx == IDX_W'(REG_ICLR)) ? host_wdata[IRQ_NUM-1:0] : '0;

   nss_irq #(.N(IRQ_NUM)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .ev     (iev),
      .set_wr (iset),
      .clr_wr (iclr),
      .en_we  (reg_wr && idx == IDX_W'(REG_IEN)),
      .en_d   (host_wdata[IRQ_NUM-1:0]),
      .stat   (istat),
      .en     (ien),
      .irq    (irq)
   );

   // read mux and acknowledge
   logic [HOST_W-1:0] reg_rd;

   always_comb begin
      reg_rd = '0;
      unique case (idx)
         IDX_W'(REG_CFG):   reg_rd[CFG_FORCE_CE_BIT] = force_ce;
         IDX_W'(REG_TIME):  reg_rd[TIM_W-1:0]        = timing;
         IDX_W'(REG_STAT):  reg_rd[0]                = rdy_q;
         IDX_W'(REG_ISTAT): reg_rd[IRQ_NUM-1:0]      = istat;
         IDX_W'(REG_IEN):   reg_rd[IRQ_NUM-1:0]      = ien;
         IDX_W'(REG_COUNT): reg_rd[TC_W-1:0]         = tcount;
         default:           reg_rd                   = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_ack   <= 1'b0;
         host_rdata <= '0;
      end else begin
         host_ack <= reg_go || seq_done;
         if (reg_go && !host_we)      host_rdata <= reg_rd;
         else if (seq_done && cur_rd) host_rdata <= HOST_W'(rd_q);
      end
   end

   assign nand_cle  = seq_cle;
   assign nand_ale  = seq_ale;
   assign nand_nwe  = seq_nwe;
   assign nand_nre  = seq_nre;
   assign nand_doe  = seq_oe;
   assign nand_dout = seq_dout;
   assign nand_nce  = !(seq_act || force_ce);

   // R5: acknowledge is a single pulse
   p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);
   // R6: sampled ready holds while the previous cycle was not idle
   p_rdy_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(seq_phase) != PH_IDLE) |-> $stable(rdy_q));
   // R12: a strobe is only ever seen with chip enable asserted
   p_nce_on_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_nwe || !nand_nre) |-> !nand_nce);
   // R9: the decrement event leaves the counter at zero
   p_tc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ev && !reg_wr) |=> (tcount == '0));
endmodule

// File: tb/nand_strobe_seq_tb.sv
module nand_strobe_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [6:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        host_ack;
   logic [31:0] host_rdata;
   logic        nand_cle, nand_ale, nand_nce, nand_nwe, nand_nre, nand_doe;
   logic [7:0]  nand_dout;
   logic [7:0]  nand_din = 8'h00;
   logic        nand_rb = 1'b0;
   logic        irq;

   int checks = 0, failures = 0;
   int m_setup, m_pulse, m_hold, m_gap, m_bad;
   bit m_cle, m_ale, m_seen_act;
   logic [7:0] m_dout;
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   nand_strobe_seq u_dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
      .host_rdata(host_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_nce(nand_nce), .nand_nwe(nand_nwe), .nand_nre(nand_nre),
      .nand_dout(nand_dout), .nand_doe(nand_doe), .nand_din(nand_din),
      .nand_rb(nand_rb), .irq(irq)
   );

   localparam logic [6:0] A_CFG = 7'h40, A_TIME = 7'h44, A_STAT = 7'h48,
      A_ISTAT = 7'h4C, A_IEN = 7'h50, A_ISET = 7'h54, A_ICLR = 7'h58,
      A_CTRL = 7'h5C, A_COUNT = 7'h60;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [6:0] a, input logic [31:0] d,
                         output logic [31:0] r);
      m_setup = 0; m_pulse = 0; m_hold = 0; m_gap = 0; m_bad = 0;
      m_cle = 0; m_ale = 0; m_seen_act = 0; m_dout = '0;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (host_ack) break;
         if (nand_cle && nand_ale) m_bad++;
         if (!nand_nwe && !nand_nre) m_bad++;
         if (!nand_nce) begin
            m_seen_act = 1;
            if (nand_cle) m_cle = 1;
            if (nand_ale) m_ale = 1;
            if (!nand_nwe || !nand_nre) begin
               m_pulse++;
               m_dout = nand_dout;
            end else if (m_pulse == 0) m_setup++;
            else m_hold++;
         end else if (!m_seen_act) m_gap++;
      end
      r = host_rdata;
      host_req = 1'b0;
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      logic [31:0] dummy;
      access(1'b1, a, d, dummy);
   endtask

   task automatic rdreg(input logic [6:0] a, output logic [31:0] r);
      access(1'b0, a, 32'h0, r);
   endtask

   task automatic t_reset;
      chk(nand_nce === 1'b1 && nand_nwe === 1'b1 && nand_nre === 1'b1, "R12 idle strobes",
          {nand_nce, nand_nwe, nand_nre}, 3'b111);
      chk(nand_cle === 1'b0 && nand_ale === 1'b0 && irq === 1'b0, "R12 idle latches",
          {nand_cle, nand_ale, irq}, 0);
      rdreg(A_TIME, rd);
      chk(rd === 32'h0, "R1 timing reset", rd, 0);
      rdreg(A_CTRL, rd);
      chk(rd === 32'h0, "R11 ctrl reads zero", rd, 0);
   endtask

   task automatic t_timing_rb;
      wr(A_TIME, 32'hA5C3_4E21);
      rdreg(A_TIME, rd);
      chk(rd === 32'hA5C3_4E21, "R1 timing readback", rd, 32'hA5C3_4E21);
   endtask

   task automatic t_write_cycles;
      // write group: wait 0, width 5, hold 3, setup 2
      wr(A_TIME, 32'h0532_0000);
      wr(7'h00, 32'h3C);
      chk(m_setup == 2+1, "R2 write setup", m_setup, 3);
      chk(m_pulse == 5+1, "R2 write width", m_pulse, 6);
      chk(m_hold == 3+1, "R2 write hold", m_hold, 4);
      chk(m_dout === 8'h3C, "R2 write data", m_dout, 8'h3C);
      chk(!m_cle && !m_ale, "R4 data cycle latches", {m_cle, m_ale}, 0);
      wr(7'h08, 32'h70);
      chk(m_cle && !m_ale && m_dout === 8'h70, "R4 command cycle", {m_cle, m_ale, m_dout}, 10'h270);
      chk(m_bad == 0, "R12 exclusivity", m_bad, 0);
      wr(7'h04, 32'h12);
      chk(!m_cle && m_ale, "R4 address cycle", {m_cle, m_ale}, 2'b01);
      wr(7'h0C, 32'h55);
      chk(m_cle && !m_ale, "R4 bit3 priority", {m_cle, m_ale}, 2'b10);
   endtask

   task automatic t_read_cycle;
      // read group: wait 0, width 3, hold 0, setup 1; write group kept
      wr(A_TIME, 32'h0532_0301);
      nand_din = 8'h9A;
      access(1'b0, 7'h08, 32'h0, rd);
      chk(rd === 32'h9A, "R3 read data", rd, 32'h9A);
      chk(m_setup == 2 && m_pulse == 4 && m_hold == 1, "R3 read phases",
          {m_setup[7:0], m_pulse[7:0], m_hold[7:0]}, 24'h020401);
      chk(!m_cle && !m_ale, "R3 read has no latch", {m_cle, m_ale}, 0);
   endtask

   task automatic t_force_ce;
      wr(A_CFG, 32'h20);
      repeat (2) @(negedge clk);
      chk(nand_nce === 1'b0, "R7 forced chip enable", nand_nce, 0);
      rdreg(A_CFG, rd);
      chk(rd === 32'h20, "R7 cfg readback", rd, 32'h20);
      wr(A_CFG, 32'h0);
      repeat (2) @(negedge clk);
      chk(nand_nce === 1'b1, "R12 chip enable released", nand_nce, 1);
   endtask

   task automatic t_ready_wait;
      wr(A_TIME, 32'h0);
      wr(7'h00, 32'h01);
      wr(7'h00, 32'h02);
      chk(m_gap <= 1, "R6 no wait gap", m_gap, 0);
      wr(A_TIME, 32'h4000_0000);
      wr(7'h00, 32'h03);
      wr(7'h00, 32'h04);
      chk(m_gap >= 2*4-1, "R5 R6 next cycle held by wait", m_gap, 7);
      wr(A_ICLR, 32'h3);
      rdreg(A_STAT, rd);
      chk(rd[0] === 1'b0, "R8 busy status", rd, 0);
      wr(7'h00, 32'h05);
      nand_rb = 1'b1;
      rdreg(A_STAT, rd);
      chk(rd[0] === 1'b0, "R6 ready frozen during wait", rd, 0);
      repeat (20) @(negedge clk);
      rdreg(A_STAT, rd);
      chk(rd[0] === 1'b1, "R8 ready status", rd, 1);
      rdreg(A_ISTAT, rd);
      chk(rd[1:0] === 2'b01, "R8 ready event", rd, 1);
      wr(A_IEN, 32'h1);
      @(negedge clk);
      chk(irq === 1'b1, "R10 irq on ready", irq, 1);
      wr(A_ICLR, 32'h1);
      @(negedge clk);
      chk(irq === 1'b0, "R10 irq cleared", irq, 0);
      wr(A_TIME, 32'h0);
   endtask

   task automatic t_count;
      wr(A_IEN, 32'h0);
      wr(A_COUNT, 32'h2);
      wr(7'h08, 32'h80);
      wr(7'h04, 32'h00);
      rdreg(A_COUNT, rd);
      chk(rd === 32'h2, "R9 cmd/addr keep count", rd, 2);
      wr(7'h00, 32'hAA);
      rdreg(A_COUNT, rd);
      chk(rd === 32'h1, "R9 data decrements", rd, 1);
      rdreg(A_ISTAT, rd);
      chk(rd[1] === 1'b0, "R9 no early event", rd, 0);
      access(1'b0, 7'h00, 32'h0, rd);
      rdreg(A_COUNT, rd);
      chk(rd === 32'h0, "R9 read data decrements", rd, 0);
      rdreg(A_ISTAT, rd);
      chk(rd[1] === 1'b1, "R9 count event", rd, 2);
      wr(A_IEN, 32'h2);
      @(negedge clk);
      chk(irq === 1'b1, "R10 irq on count", irq, 1);
      wr(A_ICLR, 32'h2);
      wr(A_IEN, 32'h0);
   endtask

   task automatic t_set;
      wr(A_ISET, 32'h2);
      @(negedge clk);
      chk(irq === 1'b0, "R10 masked", irq, 0);
      rdreg(A_ISTAT, rd);
      chk(rd[1:0] === 2'b10, "R10 set register", rd, 2);
      wr(A_IEN, 32'h2);
      @(negedge clk);
      chk(irq === 1'b1, "R10 enabled", irq, 1);
      wr(A_ICLR, 32'h2);
      @(negedge clk);
      chk(irq === 1'b0, "R10 clear register", irq, 0);
   endtask

   task automatic t_soft_reset;
      wr(A_TIME, 32'h1234_5678);
      wr(A_CFG, 32'h20);
      wr(A_COUNT, 32'h5);
      wr(A_IEN, 32'h3);
      wr(A_CTRL, 32'h4);
      rdreg(A_CTRL, rd);
      chk(rd === 32'h0, "R11 ctrl self-clears", rd, 0);
      rdreg(A_TIME, rd);
      chk(rd === 32'h0, "R11 timing cleared", rd, 0);
      rdreg(A_CFG, rd);
      chk(rd === 32'h0, "R11 cfg cleared", rd, 0);
      rdreg(A_COUNT, rd);
      chk(rd === 32'h0, "R11 count cleared", rd, 0);
      rdreg(A_IEN, rd);
      chk(rd === 32'h0, "R11 enable cleared", rd, 0);
      chk(nand_nce === 1'b1, "R11 chip enable idle", nand_nce, 1);
   endtask

   int cyc = 0;
   bit done = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_timing_rb();
      t_write_cycles();
      t_read_cycle();
      t_force_ce();
      t_ready_wait();
      t_count();
      t_set();
      t_soft_reset();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule